// File: doc/BRIEF.md
# Directory Coherence State Controller

This block is the home directory for a small shared-memory system built from several processors, each with a private cache. For every memory block it keeps a sharing state and a vector with one bit per processor that marks who holds a copy. It takes read-miss and write-miss requests from the caches. It then sends control messages so that a block never has more than one writable copy. These messages are invalidate, fetch and fetch-invalidate. It finishes every request with a data reply to the requester.

A request is a processor id, a block index and a read/write flag, accepted with a valid/ready handshake. The controller handles one transaction at a time and keeps `req_ready` low until the transaction's data reply has been sent. Caches answer each invalidate or fetch on a single acknowledge channel that carries the responder's id. The directory entries are internal registers that clear to Uncached at reset.

Block states are Uncached (encoded 0), Shared (1) and Exclusive (2). Controller states are IDLE, EVAL, FETCH, WAIT, INVAL and REPLY. Their transitions are listed below.
- IDLE→EVAL when a request is accepted.
- EVAL→REPLY when no other cache must act.
- EVAL→FETCH when another processor owns the block.
- EVAL→INVAL on a write to a Shared block that has other sharers.
- FETCH→REPLY if the owner acknowledges in the same cycle; otherwise FETCH→WAIT.
- WAIT→REPLY on the owner's acknowledge.
- INVAL→REPLY once every invalidate has been sent and acknowledged.
- REPLY→IDLE.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `msg_valid` is 0 and every block is Uncached, so the first read of any block gets a data reply with no control message.
- R2: A read to an Uncached or Shared block gets only a data reply (msg_kind 3) to the requester, and the requester is added to the sharers.
- R3: A read to an Exclusive block owned by another processor sends one fetch (msg_kind 1) to the owner. The data reply is sent only after the owner's acknowledge. The block then becomes Shared with the owner and the requester as sharers.
- R4: A write to a Shared block sends one invalidate (msg_kind 0) to every sharer except the requester, one per cycle in ascending id order. The data reply is sent only after all of them are acknowledged. The block then becomes Exclusive, owned by the requester. If the requester is the only sharer, no invalidate is sent.
- R5: A write to an Uncached block gets only a data reply and leaves the block Exclusive, owned by the requester.
- R6: A write to an Exclusive block owned by another processor sends one fetch-invalidate (msg_kind 2) to the owner. After the acknowledge, the requester becomes the sole owner.
- R7: A read or write from the current owner of an Exclusive block gets only a data reply and leaves the entry unchanged.
- R8: From the cycle after a request is accepted until its data reply has been sent, `req_ready` is 0 and no further request is taken.
- R9: Every message carries the block index of the transaction in `msg_blk`.
- R10: An entry written as Exclusive has exactly one sharer bit set.
- R11: Transactions on one block leave the entries of all other blocks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_pid | input | PIDW | Requesting processor id |
| req_blk | input | BLKW | Requested block index |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| ack_valid | input | 1 | A cache acknowledges an invalidate or fetch |
| ack_pid | input | PIDW | Id of the acknowledging processor |
| msg_valid | output | 1 | Message present this cycle |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-invalidate, 3 data reply |
| msg_target | output | PIDW | Destination processor id |
| msg_blk | output | BLKW | Block the message concerns |

## Verification
The bench builds the controller with four processors and eight blocks. With four processors, a single write can require three invalidates, which exercises the ascending issue order and the rule that the requester is never invalidated. With eight blocks, the bench can use the first and last index and check that activity on one block leaves the others untouched. In a directed test the bench withholds an owner's acknowledge for several cycles to show that the controller keeps `req_ready` low and issues no data reply early.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [1:0] {
        BLK_UNC = 2'd0,
        BLK_SHR = 2'd1,
        BLK_EXC = 2'd2
    } blk_state_e;

    typedef enum logic [1:0] {
        MSG_INV       = 2'd0,
        MSG_FETCH     = 2'd1,
        MSG_FETCH_INV = 2'd2,
        MSG_DATA      = 2'd3
    } msg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_FETCH,
        ST_WAIT,
        ST_INVAL,
        ST_REPLY
    } ctl_state_e;
endpackage

// File: rtl/dir_lowbit.sv
module dir_lowbit #(
    parameter int W  = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign any = |vec;
endmodule

// File: rtl/dir_store.sv
module dir_store
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    localparam int BLKW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLKW-1:0]  rd_blk,
    output blk_state_e       rd_state,
    output logic [NPROC-1:0] rd_sharers,
    input  logic             wr_en,
    input  logic [BLKW-1:0]  wr_blk,
    input  blk_state_e       wr_state,
    input  logic [NPROC-1:0] wr_sharers
);
    blk_state_e       st_q [NBLK];
    logic [NPROC-1:0] sh_q [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[g] <= BLK_UNC;
                sh_q[g] <= '0;
            end else if (wr_en && wr_blk == BLKW'(g)) begin
                st_q[g] <= wr_state;
                sh_q[g] <= wr_sharers;
            end
        end
    end

    assign rd_state   = st_q[rd_blk];
    assign rd_sharers = sh_q[rd_blk];

    // R10: an exclusive entry names exactly one holder
    assert_excl_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == BLK_EXC) |-> ($countones(wr_sharers) == 1));
endmodule

// File: rtl/dir_fsm.sv
module dir_fsm
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    localparam int PIDW = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int BLKW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PIDW-1:0]  req_pid,
    input  logic [BLKW-1:0]  req_blk,
    input  logic             req_write,
    input  logic             ack_valid,
    input  logic [PIDW-1:0]  ack_pid,
    output logic             msg_valid,
    output logic [1:0]       msg_kind,
    output logic [PIDW-1:0]  msg_target,
    output logic [BLKW-1:0]  msg_blk,
    output logic [BLKW-1:0]  rd_blk,
    input  blk_state_e       rd_state,
    input  logic [NPROC-1:0] rd_sharers,
    input  logic [PIDW-1:0]  owner_idx,
    output logic [NPROC-1:0] issue_mask,
    input  logic [PIDW-1:0]  pick_idx,
    output logic             wr_en,
    output blk_state_e       wr_state,
    output logic [NPROC-1:0] wr_sharers
);
    ctl_state_e       state_q, state_d;
    logic [PIDW-1:0]  pid_q, pid_d, owner_q, owner_d;
    logic [BLKW-1:0]  blk_q, blk_d;
    logic             wr_q, wr_d;
    logic [NPROC-1:0] issue_q, issue_d, wait_q, wait_d;
    blk_state_e       nst_q, nst_d;
    logic [NPROC-1:0] nsh_q, nsh_d;
    logic [NPROC-1:0] req_bit, others, ack_bit;
    logic             owner_ack;

    assign req_bit   = NPROC'(1) << pid_q;
    assign others    = rd_sharers & ~req_bit;
    assign ack_bit   = ack_valid ? (NPROC'(1) << ack_pid) : '0;
    assign owner_ack = ack_valid && (ack_pid == owner_q);

    // state and transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pid_q   <= '0;
            owner_q <= '0;
            blk_q   <= '0;
            wr_q    <= 1'b0;
            issue_q <= '0;
            wait_q  <= '0;
            nst_q   <= BLK_UNC;
            nsh_q   <= '0;
        end else begin
            state_q <= state_d;
            pid_q   <= pid_d;
            owner_q <= owner_d;
            blk_q   <= blk_d;
            wr_q    <= wr_d;
            issue_q <= issue_d;
            wait_q  <= wait_d;
            nst_q   <= nst_d;
            nsh_q   <= nsh_d;
        end
    end

    // next state and transaction bookkeeping
    always_comb begin
        state_d = state_q;
        pid_d   = pid_q;
        owner_d = owner_q;
        blk_d   = blk_q;
        wr_d    = wr_q;
        issue_d = issue_q;
        wait_d  = wait_q;
        nst_d   = nst_q;
        nsh_d   = nsh_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    pid_d   = req_pid;
                    blk_d   = req_blk;
                    wr_d    = req_write;
                    state_d = ST_EVAL;
                end
            end
            ST_EVAL: begin
                state_d = ST_REPLY;
                unique case (rd_state)
                    BLK_SHR: begin
                        if (!wr_q) begin
                            nst_d = BLK_SHR;
                            nsh_d = rd_sharers | req_bit;
                        end else begin
                            nst_d = BLK_EXC;
                            nsh_d = req_bit;
                            if (others != '0) begin
                                issue_d = others;
                                wait_d  = others;
                                state_d = ST_INVAL;
                            end
                        end
                    end
                    BLK_EXC: begin
                        owner_d = owner_idx;
                        if (owner_idx == pid_q) begin
                            nst_d = BLK_EXC;
                            nsh_d = rd_sharers;
                        end else begin
                            nst_d   = wr_q ? BLK_EXC : BLK_SHR;
                            nsh_d   = wr_q ? req_bit : (rd_sharers | req_bit);
                            state_d = ST_FETCH;
                        end
                    end
                    default: begin
                        nst_d = wr_q ? BLK_EXC : BLK_SHR;
                        nsh_d = req_bit;
                    end
                endcase
            end
            ST_FETCH: state_d = owner_ack ? ST_REPLY : ST_WAIT;
            ST_WAIT:  if (owner_ack) state_d = ST_REPLY;
            ST_INVAL: begin
                if (issue_q != '0) issue_d = issue_q & ~(NPROC'(1) << pick_idx);
                wait_d = wait_q & ~ack_bit;
                if (issue_q == '0 && wait_q == '0) state_d = ST_REPLY;
            end
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        req_ready  = 1'b0;
        msg_valid  = 1'b0;
        msg_kind   = MSG_DATA;
        msg_target = pid_q;
        wr_en      = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_FETCH: begin
                msg_valid  = 1'b1;
                msg_kind   = wr_q ? MSG_FETCH_INV : MSG_FETCH;
                msg_target = owner_q;
            end
            ST_INVAL: begin
                msg_valid  = (issue_q != '0);
                msg_kind   = MSG_INV;
                msg_target = pick_idx;
            end
            ST_REPLY: begin
                msg_valid = 1'b1;
                wr_en     = 1'b1;
            end
            default: ;
        endcase
    end

    assign msg_blk    = blk_q;
    assign rd_blk     = blk_q;
    assign issue_mask = issue_q;
    assign wr_state   = nst_q;
    assign wr_sharers = nsh_q;

    // R8: an accepted request closes the door until its reply is done
    assert_hold_off_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: no data reply directly after an unanswered control message
    assert_no_early_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind != MSG_DATA && !ack_valid) |=> !(msg_valid && msg_kind == MSG_DATA));

    // R4: the writer itself is never invalidated
    assert_inval_skips_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_INV) |-> (msg_target != pid_q));

    // R4: reply held while acknowledges are still owed
    assert_reply_after_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INVAL && wait_q != '0 && !ack_valid) |=> !(msg_valid && msg_kind == MSG_DATA));
endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    localparam int PIDW = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int BLKW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [PIDW-1:0] req_pid,
    input  logic [BLKW-1:0] req_blk,
    input  logic            req_write,
    input  logic            ack_valid,
    input  logic [PIDW-1:0] ack_pid,
    output logic            msg_valid,
    output logic [1:0]      msg_kind,
    output logic [PIDW-1:0] msg_target,
    output logic [BLKW-1:0] msg_blk
);
    logic [BLKW-1:0]  rd_blk;
    blk_state_e       rd_state;
    logic [NPROC-1:0] rd_sharers;
    logic             wr_en;
    blk_state_e       wr_state;
    logic [NPROC-1:0] wr_sharers;
    logic [NPROC-1:0] issue_mask;
    logic [PIDW-1:0]  owner_idx, pick_idx;
    logic             owner_any, pick_any;

    dir_store #(.NPROC(NPROC), .NBLK(NBLK)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_blk(rd_blk), .rd_state(rd_state), .rd_sharers(rd_sharers),
        .wr_en(wr_en), .wr_blk(rd_blk), .wr_state(wr_state), .wr_sharers(wr_sharers)
    );

    dir_lowbit #(.W(NPROC)) u_owner_enc (
        .vec(rd_sharers), .idx(owner_idx), .any(owner_any)
    );

    dir_lowbit #(.W(NPROC)) u_inval_pick (
        .vec(issue_mask), .idx(pick_idx), .any(pick_any)
    );

    dir_fsm #(.NPROC(NPROC), .NBLK(NBLK)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_pid(req_pid), .req_blk(req_blk), .req_write(req_write),
        .ack_valid(ack_valid), .ack_pid(ack_pid),
        .msg_valid(msg_valid), .msg_kind(msg_kind),
        .msg_target(msg_target), .msg_blk(msg_blk),
        .rd_blk(rd_blk), .rd_state(rd_state), .rd_sharers(rd_sharers),
        .owner_idx(owner_idx), .issue_mask(issue_mask), .pick_idx(pick_idx),
        .wr_en(wr_en), .wr_state(wr_state), .wr_sharers(wr_sharers)
    );

    // R4: an invalidate is only issued for a nonempty pending set
    assert_pick_has_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_INV) |-> pick_any);

    // R10: an exclusive entry read back always has a holder
    assert_exclusive_has_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == BLK_EXC) |-> owner_any);
endmodule

// File: tb/dir_coherence_ctrl_bench.sv
`timescale 1ns/1ps
module dir_coherence_ctrl_bench;
    localparam int NPROC = 4;
    localparam int NBLK  = 8;
    localparam int NV    = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_pid = '0;
    logic [2:0] req_blk = '0;
    logic       ack_valid = 1'b0;
    logic [1:0] ack_pid = '0;
    logic       req_ready, msg_valid;
    logic [1:0] msg_kind, msg_target;
    logic [2:0] msg_blk;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #4 clk = ~clk;

    dir_coherence_ctrl #(.NPROC(NPROC), .NBLK(NBLK)) u_dir_coherence_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_pid(req_pid), .req_blk(req_blk), .req_write(req_write),
        .ack_valid(ack_valid), .ack_pid(ack_pid), .msg_valid(msg_valid),
        .msg_kind(msg_kind), .msg_target(msg_target), .msg_blk(msg_blk)
    );

    // vector: pid[11:10] blk[9:7] write[6] ctrl_kind[5:4] ctrl_mask[3:0]
    // ctrl_kind 3 with mask 0 means no control message expected
    localparam logic [11:0] VEC [NV] = '{
        {2'd0, 3'd0, 1'b0, 2'd3, 4'b0000},  // R1 R2 first read of b0
        {2'd1, 3'd0, 1'b0, 2'd3, 4'b0000},  // R2 read of shared
        {2'd2, 3'd0, 1'b1, 2'd0, 4'b0011},  // R4 invalidate P0,P1
        {2'd3, 3'd0, 1'b0, 2'd1, 4'b0100},  // R3 fetch from P2
        {2'd3, 3'd0, 1'b1, 2'd0, 4'b0100},  // R4 requester excluded
        {2'd1, 3'd0, 1'b1, 2'd2, 4'b1000},  // R6 fetch-invalidate P3
        {2'd1, 3'd0, 1'b1, 2'd3, 4'b0000},  // R7 owner writes again
        {2'd0, 3'd1, 1'b1, 2'd3, 4'b0000},  // R5 write to uncached
        {2'd2, 3'd1, 1'b0, 2'd1, 4'b0001},  // R3 fetch from P0
        {2'd0, 3'd1, 1'b0, 2'd3, 4'b0000},  // R2 sharer rereads
        {2'd1, 3'd1, 1'b1, 2'd0, 4'b0101},  // R4 R3 owner and reader both shared
        {2'd2, 3'd7, 1'b1, 2'd3, 4'b0000},  // R5 last block
        {2'd3, 3'd7, 1'b0, 2'd1, 4'b0100},  // R3
        {2'd2, 3'd0, 1'b0, 2'd1, 4'b0010},  // R11 b0 still owned by P1
        {2'd0, 3'd5, 1'b0, 2'd3, 4'b0000},  // R2
        {2'd1, 3'd5, 1'b0, 2'd3, 4'b0000},  // R2
        {2'd2, 3'd5, 1'b0, 2'd3, 4'b0000},  // R2
        {2'd3, 3'd5, 1'b1, 2'd0, 4'b0111},  // R4 three invalidates
        {2'd2, 3'd3, 1'b0, 2'd3, 4'b0000},  // R2
        {2'd2, 3'd3, 1'b1, 2'd3, 4'b0000},  // R4 sole sharer upgrades
        {2'd0, 3'd3, 1'b0, 2'd1, 4'b0100},  // R4 R3 upgrade made P2 owner
        {2'd1, 3'd1, 1'b0, 2'd3, 4'b0000}   // R7 owner rereads b1
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic issue(input logic [1:0] pid, input logic [2:0] blk, input logic wr);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_pid = pid; req_blk = blk; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // collects messages of one transaction, acknowledging each control message at once
    task automatic collect(input logic [1:0] pid, input logic [2:0] blk, input string tag,
                           output logic [1:0] kind, output logic [3:0] mask, output bit got_data,
                           output logic [1:0] data_tgt, output bit order_ok);
        int last;
        kind = 2'd3; mask = '0; got_data = 0; data_tgt = '0; order_ok = 1; last = -1;
        for (int t = 0; t < 40 && !got_data; t++) begin
            if (t != 0) @(negedge clk);
            ack_valid = 1'b0;
            if (msg_valid) begin
                check(msg_blk == blk, {tag, " R9 block field"}, msg_blk, blk);
                if (msg_kind == 2'd3) begin
                    got_data = 1; data_tgt = msg_target;
                end else begin
                    kind = msg_kind;
                    mask |= 4'b1 << msg_target;
                    if (int'(msg_target) <= last) order_ok = 0;
                    last = msg_target;
                    ack_valid = 1'b1; ack_pid = msg_target;
                end
            end
        end
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    initial begin
        logic [1:0] kind, tgt;
        logic [3:0] mask;
        bit got, ord;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset held", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(msg_valid == 1'b0, "R1 no message after reset", msg_valid, 0);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][11:10], VEC[i][9:7], VEC[i][6]);
            collect(VEC[i][11:10], VEC[i][9:7], $sformatf("vec%0d", i), kind, mask, got, tgt, ord);
            check(mask == VEC[i][3:0], $sformatf("vec%0d R3/R4/R6 control targets", i), mask, VEC[i][3:0]);
            check(kind == VEC[i][5:4], $sformatf("vec%0d R2/R3/R6 control kind", i), kind, VEC[i][5:4]);
            check(got && tgt == VEC[i][11:10], $sformatf("vec%0d R2 data reply to requester", i),
                  {got, tgt}, {1'b1, VEC[i][11:10]});
            check(ord, $sformatf("vec%0d R4 ascending invalidate order", i), ord, 1);
        end

        // R8: owner withholds its acknowledge; controller stays closed and silent
        issue(2'd0, 3'd6, 1'b1);
        collect(2'd0, 3'd6, "r5_setup", kind, mask, got, tgt, ord);
        check(got && mask == 4'b0, "R5 write to uncached b6", {got, mask}, 5'h10);
        issue(2'd1, 3'd6, 1'b0);
        // EVAL now; FETCH on the next cycle
        check(req_ready == 1'b0, "R8 ready low in evaluation", req_ready, 0);
        @(negedge clk);
        check(msg_valid && msg_kind == 2'd1 && msg_target == 2'd0, "R3 fetch to owner P0",
              {msg_valid, msg_kind, msg_target}, 5'b10100);
        req_valid = 1'b1; req_pid = 2'd2; req_blk = 3'd2; req_write = 1'b0;
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            check(req_ready == 1'b0, "R8 ready low while waiting", req_ready, 0);
            check(msg_valid == 1'b0, "R3 no reply before write-back", msg_valid, 0);
        end
        req_valid = 1'b0;
        ack_valid = 1'b1; ack_pid = 2'd0;
        @(negedge clk);
        ack_valid = 1'b0;
        check(msg_valid && msg_kind == 2'd3 && msg_target == 2'd1, "R3 reply after write-back",
              {msg_valid, msg_kind, msg_target}, 5'b11101);
        check(req_ready == 1'b0, "R8 ready low during reply", req_ready, 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R8 ready returns after reply", req_ready, 1);
        // R11: block 2 was never requested while closed, so it is still uncached
        issue(2'd3, 3'd2, 1'b1);
        collect(2'd3, 3'd2, "r11_b2", kind, mask, got, tgt, ord);
        check(got && tgt == 2'd3 && mask == 4'b0, "R11 held request had no effect on b2",
              {got, tgt, mask}, 7'b1110000);

        summary();
        $finish;
    end
endmodule